// File: doc/BRIEF.md
# Boot Start Address Test Data Register

This block is a test data register on the JTAG scan path. It lets a host set the address that a parallel-flash configuration controller starts reading from. While the register's instruction is selected, the TAP's capture, shift and update strobes act on it. A 22-bit scan chain sits between TDI and TDO. The value in that chain is committed into a separate 22-bit holding register. The holding register feeds the flash controller.

Flash boot addresses are word aligned, so the two lowest byte-address bits never need to be stored. The register keeps the target byte address divided by four. The output path rebuilds the full 24-bit byte address by placing two zero bits below the stored word.

When a host arms the remote-update feature, the address programmed here applies only to the factory image. The block latches the state of the remote-update flag at the moment of each commit. It reports that state beside the address, so the flash controller knows which image the address targets.

Top module: `jtag_boot_addr_reg`

## Requirements
- R1: While trstN is low, and right after it goes low, the holding register is zero, bootAddr is 0x000000, factoryOnly is 0 and tdo is 0.
- R2: On a rising tck edge with selected=1 and shiftDr=1, tdi enters bit 21 of the scan chain and every other bit moves one place toward bit 0.
- R3: tdo shows bit 0 of the scan chain and changes only on the falling tck edge.
- R4: On a rising edge with selected=1 and captureDr=1, the scan chain loads the current holding-register value.
- R5: On a rising edge with selected=1 and updateDr=1, the holding register takes the scan-chain value. At every other edge the holding register keeps its value.
- R6: bootAddr[23:2] equals the holding register and bootAddr[1:0] is always 0.
- R7: While selected=0, the capture, shift and update strobes change neither the scan chain nor the holding register.
- R8: On each commit (R5), factoryOnly takes the value of remoteUpdateEn. Between commits it holds its value. When factoryOnly is 1, the address applies to the factory image only.
- R9: If several strobes are high at once, capture takes priority over shift, and shift takes priority over update. Only the winning action occurs.
- R10: After a capture, 22 shifts bring the holding register out on tdo LSB first. 22 shifts followed by an update commit the word that was presented on tdi LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous reset, active low |
| selected | input | 1 | The boot-address instruction is the active instruction |
| captureDr | input | 1 | TAP is in the capture state of the data path |
| shiftDr | input | 1 | TAP is in the shift state of the data path |
| updateDr | input | 1 | TAP is in the update state of the data path |
| tdi | input | 1 | Serial data in |
| remoteUpdateEn | input | 1 | Remote-update feature is armed |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| bootAddr | output | 24 | Byte start address for the flash controller |
| factoryOnly | output | 1 | The committed address targets the factory image only |

## Verification
Several word patterns are shifted in and committed: alternating bits, all ones, and a short five-bit shift. The alternating pattern exposes a reversed or off-by-one chain. All ones shows a bit stuck low or a missing zero pad. The short shift shows that a commit takes the chain as it is, not a completed word. Readbacks after capture separate capture from update. Strobes with the instruction deselected, and strobes raised together, check gating and priority. A reset in the middle of a run and commits under both flag values cover the reset state and the factory-only marking.

// File: rtl/bootaddr_pkg.sv
package bootaddr_pkg;

  // Gated, mutually exclusive actions issued by the control to the datapath.
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } drStrobe_t;

endpackage

// File: rtl/bootaddr_ctrl.sv
module bootaddr_ctrl
  import bootaddr_pkg::*;
(
  input  logic      selected,
  input  logic      captureDr,
  input  logic      shiftDr,
  input  logic      updateDr,
  output drStrobe_t strobe
);

  // Only act while this register's instruction is active; resolve overlaps
  // in the order capture, shift, update.
  always_comb begin
    strobe = '0;
    if (selected) begin
      if (captureDr)     strobe.capture = 1'b1;
      else if (shiftDr)  strobe.shift   = 1'b1;
      else if (updateDr) strobe.update  = 1'b1;
    end
  end

endmodule

// File: rtl/bootaddr_dp.sv
module bootaddr_dp
  import bootaddr_pkg::*;
#(
  parameter int REG_W = 22,
  parameter int PAD_W = 2,
  parameter logic [REG_W-1:0] RESET_WORD = '0,
  localparam int ADDR_W = REG_W + PAD_W
) (
  input  logic              tck,
  input  logic              trstN,
  input  drStrobe_t         strobe,
  input  logic              tdi,
  input  logic              remoteUpdateEn,
  output logic              tdo,
  output logic [REG_W-1:0]  shiftWord,
  output logic [ADDR_W-1:0] bootAddr,
  output logic              factoryOnly
);

  logic [REG_W-1:0] chainQ;
  logic [REG_W:0]   chainIn;
  logic [REG_W-1:0] holdQ;
  logic             scopeQ;
  logic             tdoQ;

  // Serial input sits above the MSB, so every cell reads its upper neighbour.
  assign chainIn = {tdi, chainQ};

  for (genvar i = 0; i < REG_W; i++) begin : g_cell
    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN)              chainQ[i] <= 1'b0;
      else if (strobe.capture) chainQ[i] <= holdQ[i];
      else if (strobe.shift)   chainQ[i] <= chainIn[i+1];
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      holdQ  <= RESET_WORD;
      scopeQ <= 1'b0;
    end else if (strobe.update) begin
      holdQ  <= chainQ;
      scopeQ <= remoteUpdateEn;
    end
  end

  // Serial output is retimed to the falling edge.
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdoQ <= 1'b0;
    else        tdoQ <= chainQ[0];
  end

  assign tdo         = tdoQ;
  assign shiftWord   = chainQ;
  assign bootAddr    = {holdQ, {PAD_W{1'b0}}};
  assign factoryOnly = scopeQ;

endmodule

// File: rtl/jtag_boot_addr_reg.sv
module jtag_boot_addr_reg
  import bootaddr_pkg::*;
#(
  parameter int REG_W = 22,
  parameter int PAD_W = 2,
  parameter logic [REG_W-1:0] RESET_WORD = '0,
  localparam int ADDR_W = REG_W + PAD_W
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              selected,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  input  logic              remoteUpdateEn,
  output logic              tdo,
  output logic [ADDR_W-1:0] bootAddr,
  output logic              factoryOnly
);

  drStrobe_t        strobe;
  logic [REG_W-1:0] shiftWord;

  bootaddr_ctrl u_ctrl (
    .selected  (selected),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .strobe    (strobe)
  );

  bootaddr_dp #(
    .REG_W      (REG_W),
    .PAD_W      (PAD_W),
    .RESET_WORD (RESET_WORD)
  ) u_dp (
    .tck            (tck),
    .trstN          (trstN),
    .strobe         (strobe),
    .tdi            (tdi),
    .remoteUpdateEn (remoteUpdateEn),
    .tdo            (tdo),
    .shiftWord      (shiftWord),
    .bootAddr       (bootAddr),
    .factoryOnly    (factoryOnly)
  );

endmodule

// File: rtl/jtag_boot_addr_reg_chk.sv
module jtag_boot_addr_reg_chk #(
  parameter int REG_W = 22,
  parameter int PAD_W = 2,
  localparam int ADDR_W = REG_W + PAD_W
) (
  input logic              tck,
  input logic              trstN,
  input logic              selected,
  input logic              captureDr,
  input logic              shiftDr,
  input logic              updateDr,
  input logic              tdi,
  input logic              remoteUpdateEn,
  input logic              tdo,
  input logic [ADDR_W-1:0] bootAddr,
  input logic              factoryOnly,
  input logic [REG_W-1:0]  shiftWord
);

  a_r6_pad_zero: assert property (@(posedge tck) disable iff (!trstN)
    bootAddr[PAD_W-1:0] == '0);

  a_r3_tdo_follows_lsb: assert property (@(posedge tck) disable iff (!trstN)
    tdo == shiftWord[0]);

  a_r2_shift_move: assert property (@(posedge tck) disable iff (!trstN)
    (selected && shiftDr && !captureDr) |=>
      shiftWord == {$past(tdi), $past(shiftWord[REG_W-1:1])});

  a_r4_capture_load: assert property (@(posedge tck) disable iff (!trstN)
    (selected && captureDr) |=> shiftWord == $past(bootAddr[ADDR_W-1:PAD_W]));

  a_r5_commit: assert property (@(posedge tck) disable iff (!trstN)
    (selected && updateDr && !captureDr && !shiftDr) |=>
      bootAddr[ADDR_W-1:PAD_W] == $past(shiftWord));

  a_r5_hold: assert property (@(posedge tck) disable iff (!trstN)
    !(selected && updateDr) |=> $stable(bootAddr) && $stable(factoryOnly));

  a_r7_deselected: assert property (@(posedge tck) disable iff (!trstN)
    !selected |=> $stable(shiftWord) && $stable(bootAddr));

  a_r8_scope_latch: assert property (@(posedge tck) disable iff (!trstN)
    (selected && updateDr && !captureDr && !shiftDr) |=>
      factoryOnly == $past(remoteUpdateEn));

endmodule

bind jtag_boot_addr_reg jtag_boot_addr_reg_chk #(
  .REG_W (REG_W),
  .PAD_W (PAD_W)
) u_chk (
  .tck            (tck),
  .trstN          (trstN),
  .selected       (selected),
  .captureDr      (captureDr),
  .shiftDr        (shiftDr),
  .updateDr       (updateDr),
  .tdi            (tdi),
  .remoteUpdateEn (remoteUpdateEn),
  .tdo            (tdo),
  .bootAddr       (bootAddr),
  .factoryOnly    (factoryOnly),
  .shiftWord      (shiftWord)
);

// File: tb/sim_jtag_boot_addr_reg.sv
module sim_jtag_boot_addr_reg;

  localparam int CLK_PERIOD = 10;
  localparam int W = 22;

  logic        tck = 1'b0;
  logic        trstN = 1'b0;
  logic        selected = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic        tdi = 1'b0, remoteUpdateEn = 1'b0;
  logic        tdo, factoryOnly;
  logic [23:0] bootAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  bit          mq[$];
  logic [W-1:0] mHold;
  bit          mScope;
  bit          mTdo;

  jtag_boot_addr_reg u0 (
    .tck(tck), .trstN(trstN), .selected(selected), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi),
    .remoteUpdateEn(remoteUpdateEn), .tdo(tdo), .bootAddr(bootAddr),
    .factoryOnly(factoryOnly)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  function automatic logic [W-1:0] packQ();
    logic [W-1:0] v = '0;
    for (int i = 0; i < W; i++) v[i] = mq[i];
    return v;
  endfunction

  task automatic modelReset();
    mq.delete();
    for (int i = 0; i < W; i++) mq.push_back(1'b0);
    mHold = '0; mScope = 1'b0; mTdo = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(input string tag);
    check({tag, " R6 bootAddr"}, {8'h0, bootAddr}, {8'h0, mHold, 2'b00});
    check("R6 pad bits", {30'h0, bootAddr[1:0]}, 32'h0);
    check({tag, " R8 factoryOnly"}, {31'h0, factoryOnly}, {31'h0, mScope});
  endtask

  // One tck period: inputs were set after the previous falling edge.
  task automatic cycle(input string tag, input bit sel, input bit cap, input bit sh,
                       input bit upd, input bit din, input bit flag);
    selected = sel; captureDr = cap; shiftDr = sh; updateDr = upd;
    tdi = din; remoteUpdateEn = flag;
    @(posedge tck);
    if (sel) begin
      if (cap) begin
        mq.delete();
        for (int i = 0; i < W; i++) mq.push_back(mHold[i]);
      end else if (sh) begin
        void'(mq.pop_front());
        mq.push_back(din);
      end else if (upd) begin
        mHold = packQ();
        mScope = flag;
      end
    end
    #1;
    checkOutputs(tag);
    check("R3 tdo before falling edge", {31'h0, tdo}, {31'h0, mTdo});
    @(negedge tck);
    mTdo = mq[0];
    #1;
    check({tag, " R3 tdo"}, {31'h0, tdo}, {31'h0, mTdo});
  endtask

  task automatic writeWord(input string tag, input logic [W-1:0] val, input bit flag);
    cycle(tag, 1, 1, 0, 0, 0, flag);
    for (int i = 0; i < W; i++) cycle({tag, " R2"}, 1, 0, 1, 0, val[i], flag);
    cycle({tag, " R5"}, 1, 0, 0, 1, 0, flag);
    check({tag, " R10 committed"}, {8'h0, bootAddr}, {8'h0, val, 2'b00});
  endtask

  task automatic readWord(input string tag, input logic [W-1:0] exp);
    logic [W-1:0] got = '0;
    cycle({tag, " R4"}, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < W; i++) begin
      got[i] = tdo;
      cycle({tag, " R10"}, 1, 0, 1, 0, 0, 0);
    end
    check({tag, " R10 readback"}, {10'h0, got}, {10'h0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    #(CLK_PERIOD * 2 + 1);
    // R1: reset state
    checkOutputs("R1 reset");
    check("R1 tdo reset", {31'h0, tdo}, 32'h0);
    @(negedge tck); #1;
    trstN = 1'b1;

    writeWord("alt", 22'h2AAAAA, 1'b0);
    readWord("alt", 22'h2AAAAA);
    writeWord("ones", 22'h3FFFFF, 1'b1);
    readWord("ones", 22'h3FFFFF);

    // R7: deselected strobes have no effect
    for (int i = 0; i < 6; i++) cycle("R7 idle", 0, i == 0, i > 0, i == 5, i[0], 0);
    cycle("R7 update deselected", 0, 0, 0, 1, 1, 0);
    readWord("R7 after", 22'h3FFFFF);

    // R9: overlapping strobes
    writeWord("mid", 22'h12345, 1'b0);
    for (int i = 0; i < 3; i++) cycle("R9 shift", 1, 0, 1, 0, 1, 1);
    cycle("R9 all strobes", 1, 1, 1, 1, 1, 1);
    check("R9 capture wins", {8'h0, bootAddr}, {8'h0, 22'h12345, 2'b00});
    cycle("R9 shift over update", 1, 0, 1, 1, 1, 1);
    check("R9 no commit", {31'h0, factoryOnly}, 32'h0);

    // Short shift then commit
    cycle("R5 short", 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cycle("R5 short", 1, 0, 1, 0, 1, 0);
    cycle("R5 short commit", 1, 0, 0, 1, 0, 1);
    check("R5 short value", {8'h0, bootAddr}, {8'h0, (22'h12345 >> 5) | 22'h3E0000, 2'b00});
    for (int i = 0; i < 4; i++) cycle("R5 hold", 1, 0, 0, 0, 1, 0);

    // R1: asynchronous reset mid-run
    trstN = 1'b0;
    #1;
    modelReset();
    checkOutputs("R1 midrun");
    check("R1 tdo midrun", {31'h0, tdo}, 32'h0);
    @(negedge tck); #1;
    trstN = 1'b1;
    readWord("R1 after", 22'h0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule